// File: doc/BRIEF.md
# Reset Supervisor with Watchdog

This block merges several reset sources into one active-low system reset. The sources are a manual reset pin, a watchdog that must be kicked with falling edges, and under-voltage and over-voltage flags for four supply channels. An external comparator produces those flags. Each flag kind on each channel has its own enable bit that lets it cause reset. When the last active cause goes away, the block holds reset low for a further programmed number of prescaler ticks.

The manual reset and watchdog inputs pass through two-flop synchronizers. The watchdog is cleared only by a synchronized high-to-low transition, so holding the pin low never keeps it satisfied. Both periods are counted in ticks of a shared tick-enable input, which lets long periods fit in narrow counters.

A hold output pauses an external power-up sequencer while reset is low and the sequencer reports that it is busy. Because the sequencer is paused and not restarted, it carries on from the step where it stopped once reset releases.

Top module: `rst_supervisor`

## Requirements
- R1: When `man_rst_n` is driven low, `rst_n_out` is still high after the first following rising clock edge and is low after the second. It stays low for as long as the pin stays low.
- R2: Reset is stretched after the last cause clears. A stretch counter restarts at zero on every edge at which any cause is present. Each edge with no cause and `tick` high adds one to it. `rst_n_out` rises on the edge at which the counter already equals `rst_timeout`. After `man_rst_n` returns high with `tick` held high, reset is therefore released on the (`rst_timeout`+3)th edge.
- R3: The watchdog counter is cleared only by a falling edge of `wd_kick`, and that edge takes effect on the third clock edge after the pin falls. A steady low level, or a rising edge, does not clear it.
- R4: The watchdog counter counts ticks while reset is released. When it reaches `wd_timeout` (which must be at least 1), reset goes low in that same cycle and is then stretched as in R2.
- R5: Bit i of `uv_flag`/`ov_flag` is channel i's under-/over-voltage flag. That flag causes reset only when bit i of `uv_en`/`ov_en` is 1. A flag whose enable is 0 has no effect on `rst_n_out`.
- R6: An enabled voltage flag pulls `rst_n_out` low in the same cycle, with no synchronizer delay. After it clears, release follows on the (`rst_timeout`+1)th edge.
- R7: `seq_hold` is 1 exactly when `rst_n_out` is 0 and `seq_busy` is 1. It is 0 whenever `seq_busy` is 0.
- R8: While `tick` is 0, neither the stretch counter nor the watchdog counter advances. A pending release with a nonzero timeout waits, and the watchdog does not expire.
- R9: While `arst_n` is low, `rst_n_out` is 0. The synchronizers reset to the idle-high level of the pins. After `arst_n` rises, reset releases on the (`rst_timeout`+1)th edge, with no spurious watchdog kick.
- R10: The watchdog counter is held at zero while reset is asserted. After each release it starts a fresh period of `wd_timeout` ticks, however long reset lasted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| tick | input | 1 | Prescaler tick enable for both timeouts |
| man_rst_n | input | 1 | Manual reset pin, active low, idle high |
| wd_kick | input | 1 | Watchdog kick pin, cleared on falling edge, idle high |
| uv_flag | input | NCH | Under-voltage flags, bit i = channel i |
| ov_flag | input | NCH | Over-voltage flags, bit i = channel i |
| uv_en | input | NCH | Under-voltage reset enables |
| ov_en | input | NCH | Over-voltage reset enables |
| rst_timeout | input | TW | Reset stretch length in ticks |
| wd_timeout | input | TW | Watchdog period in ticks |
| seq_busy | input | 1 | External sequencer reports a power-up in progress |
| rst_n_out | output | 1 | System reset, active low |
| seq_hold | output | 1 | Pause request to the sequencer |

## Verification
The hardest case to set up is a watchdog that expires while its pin is held low. It requires exactly one synchronized falling edge, then a full period with no further edge, and it must start from a known counter value. The bench reaches this state by driving the kick pin low on the very sample at which reset releases. It then counts high samples: the period plus the three-edge edge-detect latency. Next it lets the same low level run through a second full period with no edge at all. Timeouts, voltage-flag masks and watchdog periods are swept over small values, and each release instant is predicted from the counter rules.

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int NCH = 4,
  parameter int TW  = 16
) (
  input  logic           clk,
  input  logic           arst_n,
  input  logic           tick,
  input  logic           man_rst_n,
  input  logic           wd_kick,
  input  logic [NCH-1:0] uv_flag,
  input  logic [NCH-1:0] ov_flag,
  input  logic [NCH-1:0] uv_en,
  input  logic [NCH-1:0] ov_en,
  input  logic [TW-1:0]  rst_timeout,
  input  logic [TW-1:0]  wd_timeout,
  input  logic           seq_busy,
  output logic           rst_n_out,
  output logic           seq_hold
);

  logic [1:0]    mr_sync;
  logic [2:0]    wd_sync;
  logic          rst_active;
  logic [TW-1:0] rcnt;
  logic [TW-1:0] wcnt;

  wire mr_s       = mr_sync[1];
  wire wd_fall    = wd_sync[2] & ~wd_sync[1];
  wire volt_fault = |(uv_flag & uv_en) | |(ov_flag & ov_en);
  wire wd_exp     = ~rst_active & (wcnt >= wd_timeout);
  wire cause      = ~mr_s | volt_fault | wd_exp;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      mr_sync <= '1;
      wd_sync <= '1;
    end else begin
      mr_sync <= {mr_sync[0], man_rst_n};
      wd_sync <= {wd_sync[1:0], wd_kick};
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rst_active <= 1'b1;
      rcnt       <= '0;
    end else if (cause) begin
      rst_active <= 1'b1;
      rcnt       <= '0;
    end else if (rst_active) begin
      if (rcnt >= rst_timeout) rst_active <= 1'b0;
      else if (tick)           rcnt <= rcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                            wcnt <= '0;
    else if (rst_active || wd_fall)         wcnt <= '0;
    else if (tick && (wcnt < wd_timeout))   wcnt <= wcnt + 1'b1;
  end

  assign rst_n_out = ~(rst_active | cause);
  assign seq_hold  = seq_busy & ~rst_n_out;

  // R1
  mr_assert_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(mr_s) |=> rst_active);

  // R2
  release_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_n_out) |-> ($past(rcnt) >= $past(rst_timeout)));

  // R4
  wd_fire_chk: assert property (@(posedge clk) disable iff (!arst_n)
    wd_exp |=> rst_active);

  // R5
  mask_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (((uv_flag & uv_en) != '0) || ((ov_flag & ov_en) != '0)) |-> !rst_n_out);

  // R8
  freeze_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (!tick && rst_active && !cause) |=> $stable(rcnt));

  // R10
  wd_clear_chk: assert property (@(posedge clk) disable iff (!arst_n)
    rst_active |=> (wcnt == '0));

endmodule

// File: tb/tb_rst_supervisor.sv
module tb_rst_supervisor;
  localparam int NCH = 4;
  localparam int TW  = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           arst_n, tick, man_rst_n, wd_kick, seq_busy;
  logic [NCH-1:0] uv_flag, ov_flag, uv_en, ov_en;
  logic [TW-1:0]  rst_timeout, wd_timeout;
  logic           rst_n_out, seq_hold;

  rst_supervisor #(.NCH(NCH), .TW(TW)) dut (
    .clk(clk), .arst_n(arst_n), .tick(tick), .man_rst_n(man_rst_n),
    .wd_kick(wd_kick), .uv_flag(uv_flag), .ov_flag(ov_flag),
    .uv_en(uv_en), .ov_en(ov_en), .rst_timeout(rst_timeout),
    .wd_timeout(wd_timeout), .seq_busy(seq_busy),
    .rst_n_out(rst_n_out), .seq_hold(seq_hold)
  );

  int n_chk  = 0;
  int n_fail = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_low(output int n);
    n = 0;
    @(negedge clk);
    while (!rst_n_out && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic count_high(output int n);
    n = 1;
    @(negedge clk);
    while (rst_n_out && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic mr_pulse(input int len);
    int n;
    man_rst_n = 1'b0;
    cyc(len);
    man_rst_n = 1'b1;
    count_low(n);
  endtask

  initial begin
    #1200000;
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n, h, lows;
    arst_n = 1'b0; tick = 1'b1; man_rst_n = 1'b1; wd_kick = 1'b1; seq_busy = 1'b0;
    uv_flag = '0; ov_flag = '0; uv_en = '1; ov_en = '1;
    rst_timeout = 16'd3; wd_timeout = '1;
    cyc(3);
    chk("R9 reset held during arst_n", int'(rst_n_out), 0);
    chk("R7 hold low when not busy", int'(seq_hold), 0);
    arst_n = 1'b1;
    count_low(n);
    chk("R9 power-on stretch", n, 3);

    // R1 / R2 sweep over timeout and pulse length
    for (int t = 0; t < 5; t++) begin
      for (int l = 1; l < 4; l++) begin
        rst_timeout = TW'(t);
        man_rst_n = 1'b0;
        @(negedge clk);
        chk("R1 still high after one edge", int'(rst_n_out), 1);
        @(negedge clk);
        chk("R1 low after two edges", int'(rst_n_out), 0);
        cyc(l);
        chk("R1 low while pin low", int'(rst_n_out), 0);
        man_rst_n = 1'b1;
        count_low(n);
        chk("R2 manual stretch", n, t + 2);
      end
    end

    // R6 voltage fault sweep
    for (int t = 0; t < 5; t++) begin
      for (int k = 0; k < 2; k++) begin
        rst_timeout = TW'(t);
        if (k == 0) uv_flag[t % NCH] = 1'b1; else ov_flag[t % NCH] = 1'b1;
        #1;
        chk("R6 same-cycle fault reset", int'(rst_n_out), 0);
        cyc(2);
        @(negedge clk);
        uv_flag = '0; ov_flag = '0;
        count_low(n);
        chk("R6 fault stretch", n, t);
      end
    end

    // R5 exhaustive mask sweep
    rst_timeout = 16'd1;
    for (int ch = 0; ch < NCH; ch++) begin
      for (int k = 0; k < 2; k++) begin
        for (int en = 0; en < 2; en++) begin
          logic [NCH-1:0] bitv;
          bitv = NCH'(1) << ch;
          if (k == 0) begin
            uv_en = en ? bitv : ~bitv; ov_en = en ? '0 : '1;
            uv_flag = bitv;
          end else begin
            ov_en = en ? bitv : ~bitv; uv_en = en ? '0 : '1;
            ov_flag = bitv;
          end
          #1;
          chk("R5 mask immediate", int'(rst_n_out), en ? 0 : 1);
          cyc(3);
          chk("R5 mask held", int'(rst_n_out), en ? 0 : 1);
          uv_flag = '0; ov_flag = '0;
          if (en != 0) begin
            count_low(n);
            chk("R5 enabled flag stretch", n, 1);
          end else begin
            cyc(2);
            chk("R5 masked flag no effect", int'(rst_n_out), 1);
          end
          @(negedge clk);
        end
      end
    end
    uv_en = '1; ov_en = '1;

    // R4 watchdog expiry sweep
    rst_timeout = 16'd2;
    for (int w = 1; w < 5; w++) begin
      wd_timeout = TW'(w);
      mr_pulse(3);
      count_high(h);
      chk("R4 watchdog period", h, w);
      count_low(n);
      chk("R4 watchdog reset stretch", n, 3);
      wd_timeout = '1;
    end

    // R3 pin held low: one falling edge, then no clearing
    wd_timeout = 16'd6;
    mr_pulse(3);
    wd_kick = 1'b0;
    count_high(h);
    chk("R3 single falling edge delays expiry", h, 9);
    count_low(n);
    chk("R3 stretch after expiry", n, 3);
    count_high(h);
    chk("R3 steady low does not clear", h, 6);
    count_low(n);
    chk("R3 second stretch", n, 3);
    wd_kick = 1'b1;
    wd_timeout = '1;

    // R3 regular kicking keeps reset released
    wd_timeout = 16'd8;
    mr_pulse(3);
    lows = 0;
    for (int i = 0; i < 100; i++) begin
      wd_kick = ((i % 4) < 2) ? 1'b0 : 1'b1;
      @(negedge clk);
      if (!rst_n_out) lows++;
    end
    chk("R3 kicked watchdog never fires", lows, 0);
    wd_kick = 1'b1;
    wd_timeout = '1;

    // R10 fresh period after long reset
    wd_timeout = 16'd4;
    man_rst_n = 1'b0;
    cyc(50);
    man_rst_n = 1'b1;
    count_low(n);
    chk("R10 long reset stretch", n, 4);
    count_high(h);
    chk("R10 fresh watchdog period", h, 4);
    count_low(n);
    chk("R10 stretch after expiry", n, 3);
    wd_timeout = '1;

    // R8 tick freeze
    rst_timeout = 16'd3;
    man_rst_n = 1'b0;
    cyc(3);
    man_rst_n = 1'b1;
    tick = 1'b0;
    cyc(40);
    chk("R8 stretch frozen without tick", int'(rst_n_out), 0);
    tick = 1'b1;
    count_low(n);
    chk("R8 stretch resumes with tick", n, 3);
    wd_timeout = 16'd3;
    tick = 1'b0;
    lows = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!rst_n_out) lows++;
    end
    chk("R8 watchdog frozen without tick", lows, 0);
    wd_timeout = '1;
    tick = 1'b1;

    // R7 sequencer hold
    seq_busy = 1'b1;
    cyc(2);
    chk("R7 no hold while released", int'(seq_hold), 0);
    man_rst_n = 1'b0;
    cyc(2);
    chk("R7 hold during manual reset", int'(seq_hold), 1);
    man_rst_n = 1'b1;
    count_low(n);
    chk("R7 hold drops on release", int'(seq_hold), 0);
    uv_flag[2] = 1'b1;
    #1;
    chk("R7 hold during fault", int'(seq_hold), 1);
    seq_busy = 1'b0;
    #1;
    chk("R7 no hold when idle", int'(seq_hold), 0);
    chk("R7 reset still low", int'(rst_n_out), 0);
    @(negedge clk);
    uv_flag = '0;
    count_low(n);
    chk("R2 release after fault", n, 3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule